// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects an internal request/response port to an external 128K x 8 asynchronous static RAM. A client presents a read or write with a 17-bit word address (and a byte for writes) on a ready/valid handshake. The controller then runs the memory pins through a fixed sequence. Each phase lasts a number of system clock cycles set by a parameter, so one design can be tuned to the speed grade of the memory that is fitted.

Every pin the controller drives comes from a register. Between transactions the memory is held deselected: the active-low select is high and the active-high select is low. A read keeps both selects and the output enable active for the access window. At the end of that window the byte is captured, and it is returned on a one-cycle response strobe. A write is bounded by the write-enable pulse, with output enable held high the whole time. The controller's own data drivers switch on one guard cycle after write enable falls and switch off one cycle after it rises. The address changes only while the memory is deselected.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high, the memory is in standby: `mem_ce_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, and `rsp_valid`=0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole transaction, and a request that is raised and dropped while the controller is busy has no effect on memory contents.
- R3: A read holds `mem_ce_n`=0, `mem_ce2`=1, `mem_we_n`=1 and `mem_oe_n`=0 for exactly RD_CYC consecutive cycles.
- R4: The read byte appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle. It appears RD_CYC+1 cycles after the accepting edge.
- R5: A write holds `mem_oe_n`=1 throughout. `mem_we_n` is low for exactly WR_PULSE_CYC cycles, and both selects stay active across the rising edge of write enable.
- R6: `mem_addr` does not change while the memory is selected. It takes a new value only at the accepting edge.
- R7: `mem_dq_oe` is never high in the first cycle of the write pulse, and never high while `mem_oe_n` is low. The bus is driven for at least two cycles before write enable rises, and for one more cycle after it rises.
- R8: A byte written to any 17-bit address, including 0 and 0x1FFFF, reads back unchanged. An address never written reads as the memory's power-up content.
- R9: After a read the controller returns to idle (ready, memory deselected) RD_CYC+2 cycles after acceptance. After a write it returns to idle SETUP_CYC+WR_PULSE_CYC+RECOV_CYC+1 cycles after acceptance. A request already waiting is taken on the next edge.
- R10: `rsp_valid` is never raised by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle strobe marking read data |
| rsp_rdata | output | 8 | Captured read byte |
| mem_addr | output | 17 | Memory address bus |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus drivers |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
Every cycle, the assertions check the pin-ordering rules:
- standby whenever the controller is idle;
- output enable high while write enable is low;
- no driver overlap with output enable;
- no driving in the first pulse cycle;
- a stable address while selected;
- a single-cycle response that only a read can produce.

Only the bench scenarios can show the rest: the exact phase lengths, read latency, return to idle, data integrity at the address extremes, and that a request withdrawn while busy leaves memory unchanged. These are checked against a behavioural memory that returns a wrong byte if data is captured before the access time.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_CAP,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOV
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic ce2;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pins_t;

    localparam pins_t PINS_STANDBY = '{ce_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // phase length depends on an exact countdown (R3, R5)
    assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W        = 4,
    parameter int SETUP_CYC    = 1,
    parameter int RD_CYC       = 3,
    parameter int WR_PULSE_CYC = 3,
    parameter int RECOV_CYC    = 1
) (
    input  phase_e           phase_q,
    input  logic             start,
    input  logic             start_wr,
    input  logic             expired,
    output phase_e           phase_d,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RD    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(WR_PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RECOV = CNT_W'(RECOV_CYC - 1);

    always_comb begin
        phase_d  = phase_q;
        load     = 1'b0;
        load_val = '0;
        unique case (phase_q)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (start_wr) begin
                        phase_d  = ST_WR_SETUP;
                        load_val = LD_SETUP;
                    end else begin
                        phase_d  = ST_RD_ACC;
                        load_val = LD_RD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (expired) phase_d = ST_RD_CAP;
            end
            ST_RD_CAP: begin
                phase_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (expired) begin
                    phase_d  = ST_WR_PULSE;
                    load     = 1'b1;
                    load_val = LD_PULSE;
                end
            end
            ST_WR_PULSE: begin
                if (expired) begin
                    phase_d  = ST_WR_RECOV;
                    load     = 1'b1;
                    load_val = LD_RECOV;
                end
            end
            ST_WR_RECOV: begin
                if (expired) phase_d = ST_IDLE;
            end
            default: phase_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/sram_pin_encode.sv
module sram_pin_encode
    import sram_ctrl_pkg::*;
(
    input  phase_e phase,
    input  logic   first,
    output pins_t  pins
);
    always_comb begin
        pins = PINS_STANDBY;
        unique case (phase)
            ST_RD_ACC:   pins = '{ce_n: 1'b0, ce2: 1'b1, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
            ST_WR_SETUP: pins = '{ce_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
            ST_WR_PULSE: pins = '{ce_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b0, dq_oe: !first};
            ST_WR_RECOV: pins = '{ce_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: first};
            default:     pins = PINS_STANDBY;
        endcase
    end

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W       = 17,
    parameter int DATA_W       = 8,
    parameter int SETUP_CYC    = 1,
    parameter int RD_CYC       = 3,
    parameter int WR_PULSE_CYC = 3,
    parameter int RECOV_CYC    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int CNT_W = $clog2(SETUP_CYC + RD_CYC + WR_PULSE_CYC + RECOV_CYC + 1);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rsp_valid;
        pins_t             pins;
    } regs_t;

    localparam regs_t RST_VAL = '{phase: ST_IDLE, addr: '0, wdata: '0, rdata: '0,
                                  rsp_valid: 1'b0, pins: PINS_STANDBY};

    regs_t            d, q;
    phase_e           phase_d;
    pins_t            pins_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;

    assign accept = req_valid && (q.phase == ST_IDLE);

    sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_phase_seq #(
        .CNT_W        (CNT_W),
        .SETUP_CYC    (SETUP_CYC),
        .RD_CYC       (RD_CYC),
        .WR_PULSE_CYC (WR_PULSE_CYC),
        .RECOV_CYC    (RECOV_CYC)
    ) i_seq (
        .phase_q  (q.phase),
        .start    (req_valid),
        .start_wr (req_write),
        .expired  (tmr_expired),
        .phase_d  (phase_d),
        .load     (tmr_load),
        .load_val (tmr_val)
    );

    sram_pin_encode i_enc (
        .phase (phase_d),
        .first (phase_d != q.phase),
        .pins  (pins_d)
    );

    always_comb begin
        d           = q;
        d.phase     = phase_d;
        d.pins      = pins_d;
        d.rsp_valid = 1'b0;
        if (accept) begin
            d.addr = req_addr;
            if (req_write) d.wdata = req_wdata;
        end
        if (q.phase == ST_RD_ACC && tmr_expired) begin
            d.rdata     = mem_dq_in;
            d.rsp_valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assign req_ready  = (q.phase == ST_IDLE);
    assign rsp_valid  = q.rsp_valid;
    assign rsp_rdata  = q.rdata;
    assign mem_addr   = q.addr;
    assign mem_dq_out = q.wdata;
    assign mem_ce_n   = q.pins.ce_n;
    assign mem_ce2    = q.pins.ce2;
    assign mem_oe_n   = q.pins.oe_n;
    assign mem_we_n   = q.pins.we_n;
    assign mem_dq_oe  = q.pins.dq_oe;

    assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid));

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_single_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_oe_high_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_ce2));

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    assert_guard_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe);

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_rsp_from_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));

endmodule

// File: tb/test_async_sram_ctrl.sv
module test_async_sram_ctrl;
    localparam int SETUP = 1, RDC = 3, WPC = 3, REC = 1, ACC_CYC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  dq_model = 8'hEE;

    int checks = 0, errors = 0;
    logic [7:0] exp_mem [logic [16:0]];
    logic [7:0] dev_mem [logic [16:0]];

    always #10 clk = ~clk;

    async_sram_ctrl i_async_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(dq_model)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [16:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
    endfunction

    // behavioural memory and pin-order monitor
    wire sel = !mem_ce_n && mem_ce2;
    int          rd_run = 0, we_run = 0, dq_run = 0;
    logic        prev_we_n = 1'b1, prev_sel = 1'b0;
    logic [16:0] prev_addr = '0;
    logic [7:0]  hold_d = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (req_ready && (sel || !mem_we_n || !mem_oe_n || mem_dq_oe || rsp_valid))
                chk(0, "R1 standby while ready", {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
            if (sel && prev_sel && mem_addr != prev_addr)
                chk(0, "R6 address moved while selected", mem_addr, prev_addr);
            if (!mem_we_n && !mem_oe_n)
                chk(0, "R5 oe low during write pulse", mem_oe_n, 1);
            if (mem_dq_oe && !mem_oe_n)
                chk(0, "R7 bus contention", mem_dq_oe, 0);
            if (sel && !mem_we_n && prev_we_n && mem_dq_oe)
                chk(0, "R7 driven in first pulse cycle", mem_dq_oe, 0);
            if (sel && !mem_we_n) begin
                we_run++;
                if (mem_dq_oe) begin dq_run++; hold_d = mem_dq_out; end
            end else if (!prev_we_n) begin
                chk(we_run == WPC, "R5 pulse width", we_run, WPC);
                chk(dq_run >= 2, "R7 data setup cycles", dq_run, 2);
                chk(sel && mem_dq_oe, "R7 select and data held past pulse", {sel, mem_dq_oe}, 2'b11);
                dev_mem[mem_addr] = hold_d;
                we_run = 0;
                dq_run = 0;
            end
            if (sel && !mem_oe_n && mem_we_n) begin
                rd_run++;
            end else if (rd_run != 0) begin
                chk(rd_run == RDC, "R3 read window length", rd_run, RDC);
                rd_run = 0;
            end
            if (sel && !mem_oe_n && mem_we_n && rd_run >= ACC_CYC)
                dq_model = dev_mem.exists(mem_addr) ? dev_mem[mem_addr] : 8'h00;
            else
                dq_model = 8'hEE;
            prev_we_n = mem_we_n;
            prev_sel  = sel;
            prev_addr = mem_addr;
        end
    end

    // caller is at a negedge; returns at a negedge with the controller idle
    task automatic op(input bit wr, input logic [16:0] a, input logic [7:0] dat,
                      input bit poke, input logic [16:0] pa);
        int n;
        logic [7:0] e;
        e = exp_rd(a);
        req_write = wr; req_addr = a; req_wdata = dat; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        n = 1;
        req_valid = 1'b0;
        chk(!req_ready, "R2 ready low while busy", req_ready, 0);
        if (poke) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = pa; req_wdata = 8'h77;
            @(negedge clk); n++;
            req_valid = 1'b0;
        end
        if (wr) begin
            exp_mem[a] = dat;
            while (!req_ready && n < 60) begin
                if (rsp_valid) chk(0, "R10 response during write", 1, 0);
                @(negedge clk); n++;
            end
            chk(n == SETUP + WPC + REC + 1, "R9 write return to idle", n, SETUP + WPC + REC + 1);
        end else begin
            while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
            chk(n == RDC + 1, "R4 read latency", n, RDC + 1);
            chk(rsp_rdata == e, "R8 read data", rsp_rdata, e);
            @(negedge clk); n++;
            chk(!rsp_valid, "R4 single-cycle strobe", rsp_valid, 0);
            chk(req_ready && !sel, "R9 read return to idle", {req_ready, sel}, 2'b10);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [16:0] pool [8];
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(req_ready && mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
            "R1 reset state", {req_ready, mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 7'b1101100);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        op(1'b0, 17'h12345, 8'h00, 1'b0, '0);            // R8 unwritten location
        op(1'b1, 17'h00000, 8'h5A, 1'b0, '0);            // R8 low bound
        op(1'b1, 17'h1FFFF, 8'hC3, 1'b0, '0);            // R8 high bound
        op(1'b0, 17'h00000, 8'h00, 1'b0, '0);
        op(1'b0, 17'h1FFFF, 8'h00, 1'b0, '0);
        op(1'b0, 17'h00100, 8'h00, 1'b1, 17'h00100);     // R2 withdrawn request ignored
        op(1'b0, 17'h00100, 8'h00, 1'b0, '0);
        op(1'b1, 17'h00100, 8'hA5, 1'b1, 17'h00100);
        op(1'b0, 17'h00100, 8'h00, 1'b0, '0);
        // constrained random mix
        for (int i = 0; i < 8; i++) pool[i] = 17'($urandom);
        pool[0] = 17'h1FFFF;
        for (int i = 0; i < 400; i++) begin
            logic [16:0] a;
            bit w;
            a = ($urandom % 4 != 0) ? pool[$urandom % 8] : 17'($urandom);
            w = ($urandom % 2) == 1;
            op(w, a, 8'($urandom), 1'b0, '0);
            if ($urandom % 3 == 0) repeat ($urandom % 3) @(negedge clk);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule